// File: doc/BRIEF.md
# Accumulated-Boundary Panel Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel. Software describes the frame as a set of running boundaries rather than phase lengths: the last sync position, the last back-porch position, the last active position and the last position of the line or frame. The horizontal and vertical positions are exported so that a downstream layer stage can place its pixels. A one-cycle interrupt pulse marks the start of a chosen line.

Timing boundaries and the interrupt line are written into staging registers through a simple write port. They move into the live copy that drives the counters only when a reload is requested. The reload happens either on the next clock or at the last pixel of the current frame. The enable bit and the four polarity bits act at once. Everything runs on the pixel clock with a synchronous active-high reset.

Top module: `acc_timing_gen`

## Requirements
- R1: Timing words carry the horizontal boundary in bits 27:16 and the vertical boundary in bits 10:0. Register select 0 holds sync (pulse width minus one), 1 holds the accumulated back porch, 2 the accumulated active end, 3 the total (last position), and 6 the interrupt line in bits 10:0.
- R2: While enabled, the horizontal counter steps from 0 up to the horizontal total and returns to 0. Each return advances the vertical counter, which returns to 0 after the vertical total.
- R3: Horizontal sync is active while the horizontal counter is at or below the horizontal sync field. Vertical sync is active while the vertical counter is at or below the vertical sync field.
- R4: Data enable is active when the horizontal counter is above the horizontal back-porch boundary and at or below the horizontal active boundary, and the vertical counter meets the same two conditions against the vertical boundaries.
- R5: Register select 4 holds the polarity bits. Bit 31 set makes hsync active high, bit 30 does the same for vsync and bit 29 for data enable; a clear bit means active low. Bit 28 is driven directly on pclk_inv.
- R6: Bit 0 of register select 4 is the global enable. While it is clear, hsync, vsync and data enable sit at their inactive levels and line_irq stays low. The cycle after it is seen clear, both counters read 0.
- R7: line_irq pulses for exactly the cycle in which the horizontal counter is 0 and the vertical counter equals the interrupt line field, and only while enabled.
- R8: Writes to register selects 0, 1, 2, 3 and 6 change nothing at the outputs until a reload is performed.
- R9: Writing register select 5 with bit 0 set copies the staged timing into the live copy on the following clock edge.
- R10: Writing register select 5 with bit 1 set copies the staged timing on the edge that ends the last pixel of the current frame (both counters at their totals).
- R11: A reload request clears itself once the copy is made, so staging writes after it wait for a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Configuration write data |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| de | output | 1 | Data enable at the programmed polarity |
| pclk_inv | output | 1 | Pixel-clock inversion request |
| line_irq | output | 1 | One-cycle line-position pulse |
| h_pos | output | 12 | Current horizontal counter |
| v_pos | output | 11 | Current vertical counter |

## Verification
On every cycle the assertions check that the horizontal counter steps by one or returns to zero, and that the vertical counter holds within a line. They also check that a disabled block clears its counters and parks every strobe at its inactive level. Further checks confine the line pulse and data enable to legal positions and make an immediate reload request drop after one cycle. The bench scenarios alone show the exact boundary positions of each strobe under a concrete timing set and the polarity flip. Only the bench also shows that staged values stay hidden until a reload and the frame-end timing of the blanking reload.

// File: rtl/acc_tg_pkg.sv
package acc_tg_pkg;

    parameter int unsigned H_W    = 12;
    parameter int unsigned V_W    = 11;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned ADDR_W = 3;

    localparam int unsigned H_LSB = 16;
    localparam int unsigned V_LSB = 0;

    localparam int unsigned BIT_EN     = 0;
    localparam int unsigned BIT_PCLK   = 28;
    localparam int unsigned BIT_DE_HI  = 29;
    localparam int unsigned BIT_VS_HI  = 30;
    localparam int unsigned BIT_HS_HI  = 31;
    localparam int unsigned BIT_LD_NOW = 0;
    localparam int unsigned BIT_LD_VBL = 1;

    typedef logic [H_W-1:0]    hpos_t;
    typedef logic [V_W-1:0]    vpos_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SYNC   = 3'd0,
        SEL_PORCH  = 3'd1,
        SEL_ACTIVE = 3'd2,
        SEL_TOTAL  = 3'd3,
        SEL_CTRL   = 3'd4,
        SEL_RELOAD = 3'd5,
        SEL_LINE   = 3'd6
    } reg_sel_e;

    typedef struct packed {
        hpos_t sync_h;
        hpos_t porch_h;
        hpos_t act_h;
        hpos_t tot_h;
        vpos_t sync_v;
        vpos_t porch_v;
        vpos_t act_v;
        vpos_t tot_v;
        vpos_t line_v;
    } timing_t;

    typedef struct packed {
        logic hs_hi;
        logic vs_hi;
        logic de_hi;
        logic pclk;
    } pol_t;

    function automatic hpos_t field_h(input word_t w);
        return w[H_LSB +: H_W];
    endfunction

    function automatic vpos_t field_v(input word_t w);
        return w[V_LSB +: V_W];
    endfunction

endpackage

// File: rtl/acc_tg_cfg.sv
module acc_tg_cfg
    import acc_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  logic              frame_end,
    output timing_t           live,
    output logic              en,
    output pol_t              pol,
    output logic              req_now,
    output logic              req_vbl
);

    timing_t stage;
    logic    apply;
    logic    set_now;
    logic    set_vbl;

    assign apply   = req_now || (req_vbl && frame_end);
    assign set_now = we && (addr == SEL_RELOAD) && wdata[BIT_LD_NOW];
    assign set_vbl = we && (addr == SEL_RELOAD) && wdata[BIT_LD_VBL];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage   <= '0;
            live    <= '0;
            en      <= 1'b0;
            pol     <= '0;
            req_now <= 1'b0;
            req_vbl <= 1'b0;
        end else begin
            if (we) begin
                case (addr)
                    SEL_SYNC: begin
                        stage.sync_h <= field_h(wdata);
                        stage.sync_v <= field_v(wdata);
                    end
                    SEL_PORCH: begin
                        stage.porch_h <= field_h(wdata);
                        stage.porch_v <= field_v(wdata);
                    end
                    SEL_ACTIVE: begin
                        stage.act_h <= field_h(wdata);
                        stage.act_v <= field_v(wdata);
                    end
                    SEL_TOTAL: begin
                        stage.tot_h <= field_h(wdata);
                        stage.tot_v <= field_v(wdata);
                    end
                    SEL_LINE: stage.line_v <= field_v(wdata);
                    SEL_CTRL: begin
                        en        <= wdata[BIT_EN];
                        pol.hs_hi <= wdata[BIT_HS_HI];
                        pol.vs_hi <= wdata[BIT_VS_HI];
                        pol.de_hi <= wdata[BIT_DE_HI];
                        pol.pclk  <= wdata[BIT_PCLK];
                    end
                    default: ;
                endcase
            end
            if (apply) begin
                live <= stage;
            end
            req_now <= set_now || (req_now && !apply);
            req_vbl <= set_vbl || (req_vbl && !apply);
        end
    end

endmodule

// File: rtl/acc_tg_cnt.sv
module acc_tg_cnt
    import acc_tg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  hpos_t tot_h,
    input  vpos_t tot_v,
    output hpos_t h_cnt,
    output vpos_t v_cnt,
    output logic  frame_end
);

    logic line_end;
    logic last_line;

    assign line_end  = (h_cnt >= tot_h);
    assign last_line = (v_cnt >= tot_v);
    assign frame_end = en && line_end && last_line;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (line_end) begin
            h_cnt <= '0;
            v_cnt <= last_line ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/acc_tg_out.sv
module acc_tg_out
    import acc_tg_pkg::*;
(
    input  logic    en,
    input  hpos_t   h_cnt,
    input  vpos_t   v_cnt,
    input  timing_t live,
    input  pol_t    pol,
    output logic    hsync,
    output logic    vsync,
    output logic    de,
    output logic    line_irq
);

    localparam int unsigned N_STROBE = 3;

    logic [N_STROBE-1:0] act_vec;
    logic [N_STROBE-1:0] hi_vec;
    logic [N_STROBE-1:0] lvl_vec;
    logic                h_win;
    logic                v_win;

    assign h_win = (h_cnt > live.porch_h) && (h_cnt <= live.act_h);
    assign v_win = (v_cnt > live.porch_v) && (v_cnt <= live.act_v);

    assign act_vec[0] = en && (h_cnt <= live.sync_h);
    assign act_vec[1] = en && (v_cnt <= live.sync_v);
    assign act_vec[2] = en && h_win && v_win;

    assign hi_vec = {pol.de_hi, pol.vs_hi, pol.hs_hi};

    for (genvar i = 0; i < N_STROBE; i++) begin : g_pol
        assign lvl_vec[i] = hi_vec[i] ? act_vec[i] : !act_vec[i];
    end

    assign hsync    = lvl_vec[0];
    assign vsync    = lvl_vec[1];
    assign de       = lvl_vec[2];
    assign line_irq = en && (h_cnt == '0) && (v_cnt == live.line_v);

endmodule

// File: rtl/acc_timing_gen.sv
module acc_timing_gen
    import acc_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pclk_inv,
    output logic              line_irq,
    output logic [H_W-1:0]    h_pos,
    output logic [V_W-1:0]    v_pos
);

    timing_t live;
    pol_t    pol;
    logic    en;
    logic    req_now;
    logic    req_vbl;
    logic    frame_end;

    acc_tg_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .frame_end (frame_end),
        .live      (live),
        .en        (en),
        .pol       (pol),
        .req_now   (req_now),
        .req_vbl   (req_vbl)
    );

    acc_tg_cnt u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tot_h     (live.tot_h),
        .tot_v     (live.tot_v),
        .h_cnt     (h_pos),
        .v_cnt     (v_pos),
        .frame_end (frame_end)
    );

    acc_tg_out u_out (
        .en       (en),
        .h_cnt    (h_pos),
        .v_cnt    (v_pos),
        .live     (live),
        .pol      (pol),
        .hsync    (hsync),
        .vsync    (vsync),
        .de       (de),
        .line_irq (line_irq)
    );

    assign pclk_inv = pol.pclk;

endmodule

// File: rtl/acc_timing_gen_chk.sv
module acc_timing_gen_chk
    import acc_tg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              hs_hi,
    input logic              vs_hi,
    input logic              de_hi,
    input logic              req_now,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              hsync,
    input logic              vsync,
    input logic              de,
    input logic              line_irq,
    input logic [H_W-1:0]    h_pos,
    input logic [V_W-1:0]    v_pos
);

    logic de_on;
    logic now_set;

    assign de_on   = en && (de == de_hi);
    assign now_set = cfg_we && (cfg_addr == SEL_RELOAD) && cfg_wdata[BIT_LD_NOW];

    // R2: horizontal counter steps by one or returns to zero
    p_h_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> (h_pos == '0 || h_pos == $past(h_pos) + 1'b1));

    // R2: vertical counter holds inside a line
    p_v_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (en && h_pos != '0) |-> $stable(v_pos));

    // R6: disabled block clears its counters on the next cycle
    p_off_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (h_pos == '0 && v_pos == '0));

    // R6: disabled block parks strobes inactive
    p_off_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !en |-> (hsync == !hs_hi && vsync == !vs_hi && de == !de_hi && !line_irq));

    // R7: line pulse only at the start of a line
    p_irq_lead_r7: assert property (@(posedge clk) disable iff (rst)
        line_irq |-> (h_pos == '0 && en));

    // R4: data enable never in the first column or row
    p_de_inner_r4: assert property (@(posedge clk) disable iff (rst)
        de_on |-> (h_pos != '0 && v_pos != '0));

    // R11: immediate request drops after it is served
    p_now_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (req_now && !now_set) |=> !req_now);

endmodule

bind acc_timing_gen acc_timing_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .hs_hi     (pol.hs_hi),
    .vs_hi     (pol.vs_hi),
    .de_hi     (pol.de_hi),
    .req_now   (req_now),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .line_irq  (line_irq),
    .h_pos     (h_pos),
    .v_pos     (v_pos)
);

// File: tb/test_acc_timing_gen.sv
`timescale 1ns/1ps
module test_acc_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hsync, vsync, de, pclk_inv, line_irq;
    logic [11:0] h_pos;
    logic [10:0] v_pos;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    acc_timing_gen i_acc_timing_gen (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .hsync     (hsync),
        .vsync     (vsync),
        .de        (de),
        .pclk_inv  (pclk_inv),
        .line_irq  (line_irq),
        .h_pos     (h_pos),
        .v_pos     (v_pos)
    );

    // frame: hsync width 2, hbp 2, hactive 4, hfp 2 ; vsync 1, vbp 1, vactive 3, vfp 2
    localparam logic [31:0] W_SYNC   = (32'd1 << 16) | 32'd0;
    localparam logic [31:0] W_PORCH  = (32'd3 << 16) | 32'd1;
    localparam logic [31:0] W_ACTIVE = (32'd7 << 16) | 32'd4;
    localparam logic [31:0] W_TOTAL  = (32'd9 << 16) | 32'd6;
    localparam logic [31:0] W_LINE   = 32'd5;
    localparam logic [31:0] C_ALLHI  = 32'hE000_0001;

    // {cycle 8b, h 4b, v 4b, 4'b0, {hs,vs,de,irq} active levels}
    localparam int N_VEC = 13;
    localparam logic [23:0] VEC [N_VEC] = '{
        24'h00000C, 24'h01100C, 24'h022004, 24'h0E4100, 24'h184202,
        24'h1B7202, 24'h1C8200, 24'h2B3400, 24'h2C4402, 24'h320509,
        24'h331508, 24'h459600, 24'h46000C
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int k;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R6 / R5: reset state, all polarity bits clear -> active low, idle high
        chk({hsync, vsync, de, line_irq} == 4'b1110, "R6 reset idle levels",
            {hsync, vsync, de, line_irq}, 4'b1110);
        chk(h_pos == 0 && v_pos == 0 && !pclk_inv, "R6 reset counters",
            {h_pos, v_pos, pclk_inv}, 0);

        // R1: program timing, immediate reload (R9), enable with all-high polarity
        wr(3'd0, W_SYNC); wr(3'd1, W_PORCH); wr(3'd2, W_ACTIVE);
        wr(3'd3, W_TOTAL); wr(3'd6, W_LINE);
        wr(3'd5, 32'd1);
        wr(3'd4, C_ALLHI);
        @(negedge clk);
        k = 0;
        // R2 R3 R4 R7: vector walk over one frame
        for (int i = 0; i < N_VEC; i++) begin
            while (k < int'(VEC[i][23:16])) begin
                @(negedge clk);
                k++;
            end
            chk(h_pos == 12'(VEC[i][15:12]) && v_pos == 11'(VEC[i][11:8]),
                "R2 counter position", {h_pos, 4'h0, 5'h0, v_pos}, {12'(VEC[i][15:12]), 9'h0, 11'(VEC[i][11:8])});
            chk({hsync, vsync, de, line_irq} == VEC[i][3:0], "R3 R4 R7 strobes",
                {hsync, vsync, de, line_irq}, VEC[i][3:0]);
        end

        // R5: all active low, strobes inverted
        wr(3'd4, 32'h0000_0001);
        for (int n = 0; n < 20; n++) begin
            logic ehs, evs, ede;
            @(negedge clk);
            ehs = !(h_pos <= 1);
            evs = !(v_pos == 0);
            ede = !((h_pos > 3) && (h_pos <= 7) && (v_pos > 1) && (v_pos <= 4));
            chk({hsync, vsync, de} == {ehs, evs, ede}, "R5 active-low levels",
                {hsync, vsync, de}, {ehs, evs, ede});
        end
        wr(3'd4, 32'h1000_0001);
        @(negedge clk);
        chk(pclk_inv == 1'b1, "R5 pixel clock inversion bit", pclk_inv, 1);

        // R6: disable
        wr(3'd4, 32'h1000_0000);
        @(negedge clk);
        chk({hsync, vsync, de, line_irq} == 4'b1110, "R6 disabled idle",
            {hsync, vsync, de, line_irq}, 4'b1110);
        @(negedge clk);
        chk(h_pos == 0 && v_pos == 0, "R6 disabled counters", {h_pos, v_pos}, 0);

        // R8: staged sync change without reload has no effect
        wr(3'd0, (32'd3 << 16));
        wr(3'd4, C_ALLHI);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk(h_pos == 2 && hsync == 1'b0, "R8 staged value hidden", {h_pos, hsync}, {12'd2, 1'b0});

        // R9: immediate reload
        wr(3'd5, 32'd1);
        @(negedge clk); @(negedge clk);
        while (h_pos != 2) @(negedge clk);
        chk(hsync == 1'b1, "R9 immediate reload", hsync, 1);

        // R10: reload at frame end
        wr(3'd0, W_SYNC);
        wr(3'd5, 32'd2);
        while (!(h_pos == 2 && v_pos == 3)) @(negedge clk);
        chk(hsync == 1'b1, "R10 not before frame end", hsync, 1);
        while (!(h_pos == 2 && v_pos == 1)) @(negedge clk);
        chk(hsync == 1'b0, "R10 applied after frame end", hsync, 0);

        // R11: request cleared, later staging waits
        wr(3'd0, (32'd3 << 16));
        while (v_pos != 5) @(negedge clk);
        while (!(h_pos == 2 && v_pos == 1)) @(negedge clk);
        chk(hsync == 1'b0, "R11 request self-cleared", hsync, 0);

        finish_run();
    end

endmodule